// File: doc/BRIEF.md
# End-of-Write Status Reporter

This block sits between a nonvolatile array and its read path. It tracks one internal program or erase operation while that operation runs. A start pulse carries the operation type. For a program it also carries the top data bit of the byte being written. The block then counts the operation's duration in clock cycles. While the operation runs, the block replaces the array's read data with status bits. Software can poll these bits to learn when the write has finished.

Two status bits are reported while the operation runs:

- The top bit shows the inverted written bit during a program and a fixed 0 during an erase.
- The next bit flips after every read strobe.

When the operation ends, the block pulses a completion flag. It then holds a short settle window, during which only the top bit is trustworthy. After that window, array data passes through unchanged. An active-low reset aborts any operation at once. Other blocks can gate new commands on the busy output.

Top module: `eow_status_rpt`

## Requirements
- R1: While `rstN` is low, `busy` and `done` are 0 and `rdData` equals `arrayData`. Pulling `rstN` low during an operation ends it at once.
- R2: A `startReq` sampled while `busy` is 0 starts an operation. `busy` rises at that edge and stays high for exactly PROG_CYC cycles when `startIsErase` is 0, or ERASE_CYC cycles when it is 1.
- R3: A `startReq` sampled while `busy` is 1 has no effect: the running operation keeps its type, its written bit and its length.
- R4: While a program runs, bit DATA_W-1 of `rdData` is the inverse of the `startDq7` value captured at start.
- R5: While an erase runs, bit DATA_W-1 of `rdData` is 0.
- R6: Bit DATA_W-2 of `rdData` is 0 in the first busy cycle of every operation. While busy, it inverts in the cycle after each cycle with `rdStrobe` high, and holds otherwise.
- R7: While busy, bits DATA_W-3 down to 0 of `rdData` are 0.
- R8: `done` is high for exactly one cycle, the first cycle after `busy` falls at the end of an operation.
- R9: For SETTLE_CYC cycles after `busy` falls, bit DATA_W-1 of `rdData` holds the true value (the captured bit after a program, 1 after an erase) and all other bits are 0.
- R10: Outside busy and settle, `rdData` equals `arrayData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; aborts an operation |
| startReq | input | 1 | Start pulse for an internal operation |
| startIsErase | input | 1 | Operation type with the start: 1 erase, 0 program |
| startDq7 | input | 1 | Top data bit of the byte being programmed |
| rdStrobe | input | 1 | One-cycle marker of a host read |
| arrayData | input | DATA_W | Normal read data from the array |
| rdData | output | DATA_W | Read data or status bits |
| busy | output | 1 | High while an operation runs |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with PROG_CYC=12, ERASE_CYC=30 and SETTLE_CYC=4, with DATA_W left at 8. These short, distinct durations keep a complete erase and its settle window within a few dozen cycles. Because the program and erase lengths differ, a busy time that was wrongly taken from the ignored second start becomes visible. The short durations also leave room to abort an erase midway and to run several operations back to back, which checks that the toggle bit restarts from 0.

// File: rtl/eow_pkg.sv
package eow_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_RUN    = 2'd1,
    PH_SETTLE = 2'd2
  } eowPhase_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic loadOp;    // operation accepted this cycle
    logic running;   // internal operation in progress
    logic settling;  // post-completion settle window
  } eowStrobe_t;

endpackage

// File: rtl/eow_ctrl.sv
module eow_ctrl
  import eow_pkg::*;
#(
  parameter int PROG_CYC   = 462,
  parameter int ERASE_CYC  = 594000,
  parameter int SETTLE_CYC = 33
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       startIsErase,
  output eowStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  localparam int MAX_PE  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAX_CYC = (MAX_PE > SETTLE_CYC) ? MAX_PE : SETTLE_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] PROG_LOAD   = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD  = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);

  eowPhase_t        phase;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             cntZero;

  assign accept  = startReq && (phase != PH_RUN);
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_RUN: begin
          if (cntZero) begin
            phase <= PH_SETTLE;
            cnt   <= SETTLE_LOAD;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_SETTLE: begin
          if (accept) begin
            phase <= PH_RUN;
            cnt   <= startIsErase ? ERASE_LOAD : PROG_LOAD;
          end else if (cntZero) begin
            phase <= PH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (accept) begin
            phase <= PH_RUN;
            cnt   <= startIsErase ? ERASE_LOAD : PROG_LOAD;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.loadOp   = accept;
    strobe.running  = (phase == PH_RUN);
    strobe.settling = (phase == PH_SETTLE);
  end

  assign busy = (phase == PH_RUN);

endmodule

// File: rtl/eow_datapath.sv
module eow_datapath
  import eow_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  eowStrobe_t        strobe,
  input  logic              startIsErase,
  input  logic              startDq7,
  input  logic              rdStrobe,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData
);

  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic opErase;
  logic opDq7;
  logic togBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opErase <= 1'b0;
      opDq7   <= 1'b0;
      togBit  <= 1'b0;
    end else if (strobe.loadOp) begin
      opErase <= startIsErase;
      opDq7   <= startDq7;
      togBit  <= 1'b0;
    end else if (strobe.running && rdStrobe) begin
      togBit <= ~togBit;
    end
  end

  // polling bit
  always_comb begin
    if (strobe.running)
      rdData[POLL_BIT] = opErase ? 1'b0 : ~opDq7;
    else if (strobe.settling)
      rdData[POLL_BIT] = opErase ? 1'b1 : opDq7;
    else
      rdData[POLL_BIT] = arrayData[POLL_BIT];
  end

  // toggle bit
  always_comb begin
    if (strobe.running)
      rdData[TOG_BIT] = togBit;
    else if (strobe.settling)
      rdData[TOG_BIT] = 1'b0;
    else
      rdData[TOG_BIT] = arrayData[TOG_BIT];
  end

  // remaining bits are masked while the operation or settle is active
  generate
    for (genvar b = 0; b < TOG_BIT; b++) begin : g_low
      assign rdData[b] = (strobe.running || strobe.settling) ? 1'b0 : arrayData[b];
    end
  endgenerate

endmodule

// File: rtl/eow_status_rpt.sv
module eow_status_rpt
  import eow_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PROG_CYC   = 462,
  parameter int ERASE_CYC  = 594000,
  parameter int SETTLE_CYC = 33
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              startIsErase,
  input  logic              startDq7,
  input  logic              rdStrobe,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              done
);

  eowStrobe_t strobe;

  eow_ctrl #(
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .startIsErase(startIsErase),
    .strobe      (strobe),
    .busy        (busy),
    .done        (done)
  );

  eow_datapath #(
    .DATA_W(DATA_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .startIsErase(startIsErase),
    .startDq7    (startDq7),
    .rdStrobe    (rdStrobe),
    .arrayData   (arrayData),
    .rdData      (rdData)
  );

endmodule

// File: rtl/eow_status_chk.sv
module eow_status_chk #(
  parameter int DATA_W     = 8,
  parameter int PROG_CYC   = 462,
  parameter int ERASE_CYC  = 594000,
  parameter int SETTLE_CYC = 33
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              startIsErase,
  input logic              startDq7,
  input logic              rdStrobe,
  input logic [DATA_W-1:0] rdData,
  input logic              busy,
  input logic              done
);

  localparam int MAX_PE = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int LEN_W  = $clog2(MAX_PE + 2);

  logic             opErase;
  logic             opDq7;
  logic             prevBusy;
  logic [LEN_W-1:0] busyLen;
  logic [LEN_W-1:0] expLen;

  assign expLen = opErase ? LEN_W'(ERASE_CYC) : LEN_W'(PROG_CYC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opErase  <= 1'b0;
      opDq7    <= 1'b0;
      prevBusy <= 1'b0;
      busyLen  <= '0;
    end else begin
      prevBusy <= busy;
      busyLen  <= busy ? busyLen + 1'b1 : '0;
      if (startReq && !busy) begin
        opErase <= startIsErase;
        opDq7   <= startDq7;
      end
    end
  end

  a_r2_busy_on_start: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> busy);

  a_r2_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    (prevBusy && !busy) |-> (busyLen == expLen));

  a_r4_prog_poll: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !opErase) |-> (rdData[DATA_W-1] == ~opDq7));

  a_r5_erase_poll: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opErase) |-> (rdData[DATA_W-1] == 1'b0));

  a_r6_toggle_starts_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (rdData[DATA_W-2] == 1'b0));

  a_r6_toggle_flips: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $past(rdStrobe)) |-> (rdData[DATA_W-2] != $past(rdData[DATA_W-2])));

  a_r6_toggle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(rdStrobe)) |-> $stable(rdData[DATA_W-2]));

  a_r7_low_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (rdData[DATA_W-3:0] == '0));

  a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind eow_status_rpt eow_status_chk #(
  .DATA_W    (DATA_W),
  .PROG_CYC  (PROG_CYC),
  .ERASE_CYC (ERASE_CYC),
  .SETTLE_CYC(SETTLE_CYC)
) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startReq    (startReq),
  .startIsErase(startIsErase),
  .startDq7    (startDq7),
  .rdStrobe    (rdStrobe),
  .rdData      (rdData),
  .busy        (busy),
  .done        (done)
);

// File: tb/test_eow_status_rpt.sv
module test_eow_status_rpt;

  localparam int DW = 8;
  localparam int PC = 12;
  localparam int EC = 30;
  localparam int SC = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic          startIsErase = 1'b0;
  logic          startDq7 = 1'b0;
  logic          rdStrobe = 1'b0;
  logic [DW-1:0] arrayData = 8'h3C;
  logic [DW-1:0] rdData;
  logic          busy;
  logic          done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  eow_status_rpt #(
    .DATA_W(DW), .PROG_CYC(PC), .ERASE_CYC(EC), .SETTLE_CYC(SC)
  ) i_eow_status_rpt (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startIsErase(startIsErase),
    .startDq7(startDq7), .rdStrobe(rdStrobe), .arrayData(arrayData),
    .rdData(rdData), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // leaves the bench at the first busy sample
  task automatic pulseStart(input bit er, input bit d7);
    @(negedge clk);
    startReq = 1'b1; startIsErase = er; startDq7 = d7;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // checks the busy words, busy length, done pulse, settle words and passthrough
  task automatic runToEnd(input bit er, input bit d7, input bit tog, input int already);
    int n = already;
    logic [DW-1:0] expBusy = {(er ? 1'b0 : ~d7), tog, {(DW-2){1'b0}}};
    logic [DW-1:0] expSettle = {(er ? 1'b1 : d7), {(DW-1){1'b0}}};
    logic [DW-1:0] firstBad = '0;
    bit wordOk = 1;
    while (busy && n < 1000) begin
      if (rdData !== expBusy && wordOk) begin wordOk = 0; firstBad = rdData; end
      n++;
      @(negedge clk);
    end
    chk(wordOk, er ? "R5/R7 erase busy word" : "R4/R7 program busy word",
        firstBad, wordOk ? firstBad : expBusy);
    chk(n == (er ? EC : PC), "R2 busy length", n, er ? EC : PC);
    chk(done === 1'b1, "R8 done after busy falls", done, 1);
    for (int i = 0; i < SC; i++) begin
      chk(rdData === expSettle, "R9 settle word", rdData, expSettle);
      if (i == 1) chk(done === 1'b0, "R8 done single cycle", done, 0);
      @(negedge clk);
    end
    chk(rdData === arrayData, "R10 passthrough after settle", rdData, arrayData);
  endtask

  task automatic tReset();
    #1;
    chk(busy === 1'b0, "R1 busy in reset", busy, 0);
    chk(done === 1'b0, "R1 done in reset", done, 0);
    chk(rdData === arrayData, "R1 passthrough in reset", rdData, arrayData);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    arrayData = 8'h5A;
    #1;
    chk(rdData === 8'h5A, "R10 idle passthrough", rdData, 8'h5A);
  endtask

  task automatic tProgram(input bit d7, input logic [DW-1:0] arr);
    arrayData = arr;
    pulseStart(1'b0, d7);
    runToEnd(1'b0, d7, 1'b0, 0);
  endtask

  task automatic tErase();
    arrayData = 8'hFF;
    pulseStart(1'b1, 1'b0);
    runToEnd(1'b1, 1'b0, 1'b0, 0);
  endtask

  task automatic tToggle();
    bit pattern [8] = '{1, 0, 1, 1, 0, 0, 1, 1};  // five strobes
    bit tog = 0;
    pulseStart(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      chk(rdData[DW-2] === tog, "R6 toggle sequence", rdData[DW-2], tog);
      rdStrobe = pattern[i];
      @(negedge clk);
      if (pattern[i]) tog = ~tog;
    end
    rdStrobe = 1'b0;
    runToEnd(1'b0, 1'b0, tog, 8);
    // next operation must begin with the toggle bit at 0
    pulseStart(1'b1, 1'b0);
    chk(rdData[DW-2] === 1'b0, "R6 toggle restarts at 0", rdData[DW-2], 0);
    runToEnd(1'b1, 1'b0, 1'b0, 0);
  endtask

  task automatic tIgnore();
    pulseStart(1'b0, 1'b1);
    startReq = 1'b1; startIsErase = 1'b1; startDq7 = 1'b0;
    @(negedge clk);
    startReq = 1'b0;
    chk(rdData[DW-1] === 1'b0, "R3 second start keeps program bit", rdData[DW-1], 0);
    runToEnd(1'b0, 1'b1, 1'b0, 1);
  endtask

  task automatic tAbort();
    arrayData = 8'h81;
    pulseStart(1'b1, 1'b0);
    repeat (5) @(negedge clk);
    chk(busy === 1'b1, "R2 erase still busy", busy, 1);
    rstN = 1'b0;
    #1;
    chk(busy === 1'b0, "R1 abort drops busy", busy, 0);
    chk(rdData === 8'h81, "R1 abort restores passthrough", rdData, 8'h81);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk(done === 1'b0, "R1 no done after abort", done, 0);
    chk(rdData === 8'h81, "R10 idle after abort", rdData, 8'h81);
  endtask

  initial begin
    tReset();
    tProgram(1'b1, 8'hC3);
    tProgram(1'b0, 8'h7E);
    tErase();
    tToggle();
    tIgnore();
    tAbort();
    tProgram(1'b1, 8'h96);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule